// File: doc/BRIEF.md
# DSP Accumulator Logical Shifter

This block is the logical-shift slice of a 40-bit DSP datapath. Each accepted operation takes the upper 16-bit word (bits 31:16) of a 40-bit source value and shifts it by a signed amount. A positive amount shifts left and a negative amount shifts right. Vacated positions fill with zeros. The block returns a 40-bit result in which only bits 31:16 can be non-zero. The shift amount is a 6-bit two's-complement value. It comes either from an immediate field or from bits 21:16 of a second 40-bit source.

Alongside the result, the block produces five status flags: a selectable flag (DC), negative, zero, overflow and greater-than. It also produces two write strobes. The result strobe fires when the operation is unconditional, or when it is conditional and its condition held. The flag strobe fires only for unconditional operations, so a conditional shift never disturbs the status register. A 3-bit select input chooses what DC reports: the last bit shifted out, the sign of the result, or whether the result is zero. All outputs are registered and appear one clock after the operation is presented.

Top module: `dsp_lsh_unit`

## Requirements
- R1: Only bits 31:16 of `src1_i` affect the outputs. Bits 39:32 and 15:0 of `src1_i` are ignored.
- R2: Bits 39:32 and 15:0 of `res_o` are always zero. The shifted word appears in bits 31:16.
- R3: An amount k in 0..16 shifts the word left by k with zero fill. Amount 0 passes the word through unchanged.
- R4: An amount -m, with m in 1..16, shifts the word right logically by m. Amount -16 yields a zero word.
- R5: With `use_imm_i`=1, the amount is `imm_amt_i`. With `use_imm_i`=0, it is `src2_i[21:16]`. Both are read as 6-bit two's complement. Values outside -16..+16 have no defined result.
- R6: An operation presented with `op_valid`=1 at a rising edge shows on every output at the following edge. With `op_valid`=0, `res_o` and the flags hold their values, and both strobes are 0.
- R7: `n_o` is result bit 31. `z_o` is 1 when the whole 40-bit result is zero. `v_o` is always 0. `gt_o` is 1 when the result is neither negative nor zero.
- R8: DC follows `cond_sel_i`. Code 000 gives the last bit shifted out: source bit 16+k-... for a left shift by k this is word bit 16-k, for a right shift by m it is word bit m-1, and for amount 0 it is 0. Code 001 gives bit 31 of the result. Code 010 gives the zero condition of the result. Every other code gives 0.
- R9: `flag_we_o` is 1 only for an operation with `cond_op_i`=0. `res_we_o` is 1 for an operation with `cond_op_i`=0, or with `cond_op_i`=1 and `cond_true_i`=1.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An operation is presented this cycle |
| src1_i | input | 40 | Operand whose bits 31:16 are shifted |
| src2_i | input | 40 | Register amount source, bits 21:16 |
| imm_amt_i | input | 6 | Immediate shift amount, two's complement |
| use_imm_i | input | 1 | 1 selects the immediate amount |
| cond_op_i | input | 1 | Operation is conditional |
| cond_true_i | input | 1 | Condition of a conditional operation held |
| cond_sel_i | input | 3 | Selects the meaning of DC |
| res_o | output | 40 | Registered result |
| res_we_o | output | 1 | Result write strobe |
| flag_we_o | output | 1 | Flag write strobe |
| dc_o | output | 1 | Selectable flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag, always 0 |
| gt_o | output | 1 | Greater-than-zero flag |

## Verification
Every result, flag and strobe is due exactly one rising edge after the edge that sampled `op_valid`=1. The bench drives an operation on a falling edge, so that it is captured by the next rising edge. It then compares all outputs at the following falling edge, which is half a cycle after they update. Hold behaviour is checked one idle cycle later, at a falling edge, when the strobes must be low and the data unchanged.

// File: rtl/dsp_lsh_pkg.sv
package dsp_lsh_pkg;
  localparam logic [2:0] SEL_CARRY = 3'b000;
  localparam logic [2:0] SEL_NEG   = 3'b001;
  localparam logic [2:0] SEL_ZERO  = 3'b010;

  typedef struct packed {
    logic dc;
    logic n;
    logic z;
    logic v;
    logic gt;
  } lsh_flags_t;
endpackage

// File: rtl/lsh_amount_dec.sv
module lsh_amount_dec #(
  parameter int unsigned SRC_W   = 40,
  parameter int unsigned AMT_W   = 6,
  parameter int unsigned AMT_LSB = 16
) (
  input  logic [SRC_W-1:0] src2_i,
  input  logic [AMT_W-1:0] imm_i,
  input  logic             use_imm_i,
  output logic             left_o,
  output logic [AMT_W-1:0] mag_o
);
  logic [AMT_W-1:0] amt;

  always_comb begin
    amt    = use_imm_i ? imm_i : src2_i[AMT_LSB +: AMT_W];
    left_o = ~amt[AMT_W-1];
    mag_o  = amt[AMT_W-1] ? (~amt + {{(AMT_W-1){1'b0}}, 1'b1}) : amt;
  end
endmodule

// File: rtl/lsh_word_shifter.sv
module lsh_word_shifter #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned AMT_W  = 6
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              left_i,
  input  logic [AMT_W-1:0]  mag_i,
  output logic [WORD_W-1:0] word_o,
  output logic              carry_o
);
  localparam int unsigned EXT_W = 2 * WORD_W;

  logic [EXT_W-1:0] ext_l;
  logic [EXT_W-1:0] ext_r;

  always_comb begin
    ext_l = {{WORD_W{1'b0}}, word_i} << mag_i;
    ext_r = {word_i, {WORD_W{1'b0}}} >> mag_i;
    if (left_i) begin
      word_o  = ext_l[WORD_W-1:0];
      carry_o = ext_l[WORD_W];
    end else begin
      word_o  = ext_r[EXT_W-1:WORD_W];
      carry_o = ext_r[WORD_W-1];
    end
  end
endmodule

// File: rtl/lsh_flag_gen.sv
module lsh_flag_gen
  import dsp_lsh_pkg::*;
#(
  parameter int unsigned ACC_W    = 40,
  parameter int unsigned SIGN_POS = 31,
  parameter int unsigned SEL_W    = 3
) (
  input  logic [ACC_W-1:0] res_i,
  input  logic             carry_i,
  input  logic [SEL_W-1:0] sel_i,
  output lsh_flags_t       flags_o
);
  logic neg;
  logic zero;

  always_comb begin
    neg        = res_i[SIGN_POS];
    zero       = (res_i == '0);
    flags_o.n  = neg;
    flags_o.z  = zero;
    flags_o.v  = 1'b0;
    flags_o.gt = ~neg & ~zero;
    case (sel_i)
      SEL_CARRY: flags_o.dc = carry_i;
      SEL_NEG:   flags_o.dc = neg;
      SEL_ZERO:  flags_o.dc = zero;
      default:   flags_o.dc = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsp_lsh_unit.sv
module dsp_lsh_unit
  import dsp_lsh_pkg::*;
#(
  parameter int unsigned ACC_W    = 40,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned WORD_LSB = 16,
  parameter int unsigned AMT_W    = 6,
  parameter int unsigned AMT_LSB  = 16,
  parameter int unsigned SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [ACC_W-1:0] src1_i,
  input  logic [ACC_W-1:0] src2_i,
  input  logic [AMT_W-1:0] imm_amt_i,
  input  logic             use_imm_i,
  input  logic             cond_op_i,
  input  logic             cond_true_i,
  input  logic [SEL_W-1:0] cond_sel_i,
  output logic [ACC_W-1:0] res_o,
  output logic             res_we_o,
  output logic             flag_we_o,
  output logic             dc_o,
  output logic             n_o,
  output logic             z_o,
  output logic             v_o,
  output logic             gt_o
);
  localparam int unsigned SIGN_POS = WORD_LSB + WORD_W - 1;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              left;
  logic [AMT_W-1:0]  mag;
  logic [WORD_W-1:0] word_sh;
  logic              carry;
  logic [ACC_W-1:0]  res_d, res_q;
  lsh_flags_t        flags_d, flags_q;
  logic              res_we_d, res_we_q;
  logic              flag_we_d, flag_we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lsh_amount_dec #(.SRC_W(ACC_W), .AMT_W(AMT_W), .AMT_LSB(AMT_LSB)) u_amt (
    .src2_i(src2_i), .imm_i(imm_amt_i), .use_imm_i(use_imm_i),
    .left_o(left), .mag_o(mag)
  );

  lsh_word_shifter #(.WORD_W(WORD_W), .AMT_W(AMT_W)) u_shift (
    .word_i(src1_i[WORD_LSB +: WORD_W]), .left_i(left), .mag_i(mag),
    .word_o(word_sh), .carry_o(carry)
  );

  always_comb begin
    res_d = '0;
    res_d[WORD_LSB +: WORD_W] = word_sh;
  end

  lsh_flag_gen #(.ACC_W(ACC_W), .SIGN_POS(SIGN_POS), .SEL_W(SEL_W)) u_flags (
    .res_i(res_d), .carry_i(carry), .sel_i(cond_sel_i), .flags_o(flags_d)
  );

  always_comb begin
    res_we_d  = op_valid & (~cond_op_i | cond_true_i);
    flag_we_d = op_valid & ~cond_op_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q     <= '0;
      flags_q   <= '0;
      res_we_q  <= 1'b0;
      flag_we_q <= 1'b0;
    end else begin
      res_we_q  <= res_we_d;
      flag_we_q <= flag_we_d;
      if (op_valid) begin
        res_q   <= res_d;
        flags_q <= flags_d;
      end
    end
  end

  assign res_o     = res_q;
  assign res_we_o  = res_we_q;
  assign flag_we_o = flag_we_q;
  assign dc_o      = flags_q.dc;
  assign n_o       = flags_q.n;
  assign z_o       = flags_q.z;
  assign v_o       = flags_q.v;
  assign gt_o      = flags_q.gt;
endmodule

// File: rtl/lsh_unit_chk.sv
module lsh_unit_chk #(
  parameter int unsigned ACC_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             cond_op_i,
  input logic             cond_true_i,
  input logic [ACC_W-1:0] res_o,
  input logic             res_we_o,
  input logic             flag_we_o,
  input logic             n_o,
  input logic             z_o,
  input logic             v_o,
  input logic             gt_o
);
  AST_OUTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_o[15:0] == 16'h0) && (res_o[ACC_W-1:32] == '0)); // R2
  AST_V_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !v_o); // R7
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({n_o, z_o, gt_o})); // R7
  AST_COND_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cond_op_i) |=> !flag_we_o); // R9
  AST_COND_FALSE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cond_op_i && !cond_true_i) |=> !res_we_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(res_o) && !res_we_o && !flag_we_o)); // R6
  AST_FLAG_IMPLIES_RES: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we_o |-> res_we_o); // R9
endmodule

bind dsp_lsh_unit lsh_unit_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cond_op_i(cond_op_i),
  .cond_true_i(cond_true_i), .res_o(res_o), .res_we_o(res_we_o),
  .flag_we_o(flag_we_o), .n_o(n_o), .z_o(z_o), .v_o(v_o), .gt_o(gt_o)
);

// File: tb/dsp_lsh_unit_tb.sv
`timescale 1ns/1ps
module dsp_lsh_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [39:0] src1, src2;
  logic [5:0]  imm_amt;
  logic        use_imm, cond_op, cond_true;
  logic [2:0]  cond_sel;
  logic [39:0] res;
  logic        res_we, flag_we, dc, n, z, v, gt;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic [31:0] lfsr = 32'hACE1_2357;

  always #4 clk = ~clk;

  dsp_lsh_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .src1_i(src1), .src2_i(src2),
    .imm_amt_i(imm_amt), .use_imm_i(use_imm), .cond_op_i(cond_op),
    .cond_true_i(cond_true), .cond_sel_i(cond_sel), .res_o(res),
    .res_we_o(res_we), .flag_we_o(flag_we), .dc_o(dc), .n_o(n), .z_o(z),
    .v_o(v), .gt_o(gt)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    tests = tests + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic run_op(input logic [15:0] w, input int k, input int sel, input int mode, input bit imm);
    logic [31:0] t;
    logic [15:0] ew;
    logic        ec, en, ez, edc;
    logic [5:0]  ak;
    @(negedge clk);
    lfsr = rnd(lfsr);
    ak   = k[5:0];
    src1 = {lfsr[7:0], w, lfsr[23:8]};            // R1: noise outside 31:16
    lfsr = rnd(lfsr);
    src2 = {lfsr[31:14], imm ? ~ak : ak, lfsr[15:0]};
    imm_amt   = imm ? ak : ~ak;                    // R5: unused source carries a wrong amount
    use_imm   = imm;
    cond_sel  = sel[2:0];
    cond_op   = (mode != 0);
    cond_true = (mode == 1);
    op_valid  = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    if (k >= 0) begin
      t  = {16'h0, w} << k;
      ew = t[15:0];
      t  = {16'h0, w} >> (16 - k);
      ec = (k == 0) ? 1'b0 : t[0];
    end else begin
      t  = {16'h0, w} >> (-k);
      ew = t[15:0];
      t  = {16'h0, w} >> (-k - 1);
      ec = t[0];
    end
    en = ew[15];
    ez = (ew == 16'h0);
    case (sel)
      0: edc = ec;
      1: edc = en;
      2: edc = ez;
      default: edc = 1'b0;
    endcase
    chk("R1 R2 R3 R4 R5 result", res, {8'h0, ew, 16'h0});
    chk("R8 dc", {39'h0, dc}, {39'h0, edc});
    chk("R7 n z v gt", {36'h0, n, z, v, gt}, {36'h0, en, ez, 1'b0, ~en & ~ez});
    chk("R9 res_we", {39'h0, res_we}, {39'h0, mode != 2});
    chk("R9 flag_we", {39'h0, flag_we}, {39'h0, mode == 0});
  endtask

  initial begin
    logic [15:0] words [6];
    logic [39:0] held;
    int n_ops;
    words[0] = 16'h8001; words[1] = 16'hFFFF; words[2] = 16'h0000;
    words[3] = 16'h5A3C; words[4] = 16'h0001; words[5] = 16'h8000;
    n_ops = 0;
    rst_n = 1'b0; op_valid = 1'b0; src1 = '0; src2 = '0; imm_amt = '0;
    use_imm = 1'b0; cond_op = 1'b0; cond_true = 1'b0; cond_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset outputs", {res[31:0], res_we, flag_we, dc, n, z, v, gt}, 40'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int wi = 0; wi < 6; wi++) begin
      for (int k = -16; k <= 16; k++) begin
        for (int sel = 0; sel < 8; sel++) begin
          run_op(words[wi], k, sel, n_ops % 3, n_ops[1]);
          n_ops = n_ops + 1;
          if (n_ops % 37 == 0) begin
            held = res;
            @(negedge clk);
            chk("R6 hold result", res, held);
            chk("R6 idle strobes", {38'h0, res_we, flag_we}, 40'h0);
          end
        end
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule